// File: doc/BRIEF.md
# Configurable Trigger Match Unit

This block watches a group of probed signals on every clock and decides whether a programmed trigger condition holds. The condition belongs to one of six compare classes. Basic compares the probe bit by bit against a pattern. Extended compares the masked probe against a masked reference value using a chosen relation. Range checks that the masked probe lies between two bounds. Each of these three classes also has a variant that adds per-bit edge requirements, measured against the probe sample from the previous clock.

An occurrence counter sits after the comparator. It turns every Nth raw match into one qualified event, where N is the programmed target count. The qualified event appears as `match_o`, one cycle after the clock edge that sampled the Nth match.

Configuration is held in eight registers written through a simple write port. A synchronous arm input restarts the count. Parameters choose the probe width, the counter width, whether the group is a single full bus that may use the extended and range classes, and whether the group is enabled at all.

Top module: `trig_match_unit`

## Requirements
- R1: While reset is asserted and after it is released, `match_o` is 0. Reset sets the class to code 7, clears the counter, and clears all other configuration registers to zero.
- R2: Class code 0 (basic) matches when every probe bit whose care bit is 1 equals the corresponding value bit. Bits with care 0 are don't-care. The rise and fall registers have no effect in this class.
- R3: Class code 1 (basic with edges) handles each bit according to its rise and fall bits. A bit with only its rise bit set needs a 0-to-1 change since the previous sample. A bit with only its fall bit set needs a 1-to-0 change. A bit with both set accepts either change. A bit with neither set is a level compare when its care bit is 1, and is ignored otherwise. An edge requirement never holds before a previous sample exists.
- R4: Class code 2 (extended) compares (probe AND care) with (value AND care) as unsigned numbers. The relation code in mode bits [5:3] selects the test: 0 equal, 1 not equal, 2 greater, 3 greater or equal, 4 less, 5 less or equal. Relation codes 6 and 7 never match.
- R5: Class code 4 (range) matches when low <= (probe AND care) <= high, with both bounds inclusive.
- R6: Class codes 3 and 5 match when the extended test (code 3) or the range test (code 5) holds and the edge requirements of R3 also hold.
- R7: When the group is not a full bus (parameter EXT_OK = 0), class codes 2 to 5 never produce a match.
- R8: With a nonzero counter width, the Nth raw match since the last clear raises `match_o` for one cycle, on the cycle after that match was sampled, and the count then restarts. N is the target register value, and a target of 0 behaves as 1.
- R9: With a counter width of 0, every raw match that is not in an arm cycle raises `match_o` on the next cycle.
- R10: `arm_i` clears the counter synchronously. A raw match in the same cycle as `arm_i` is discarded, and `match_o` is 0 on the next cycle.
- R11: A disabled group (ENABLE = 0) never asserts `match_o`, whatever its configuration.
- R12: Class codes 6 and 7 never match. Register addresses on `cfg_addr_i` are: 0 mode ([2:0] class, [5:3] relation), 1 value, 2 care, 3 rise, 4 fall, 5 low bound, 6 high bound, 7 target count (low counter-width bits). A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Synchronous clear of the occurrence counter |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | WIDTH | Configuration write data |
| probe_i | input | WIDTH | Probed signal group |
| match_o | output | 1 | Qualified match pulse |

## Verification
The hardest situation to reach is an edge-qualified relation or range match. It needs a sample pair where the programmed bits move in the right direction and, in the same cycle, the masked value meets a numeric bound. Uniform random probes almost never produce this. The stimulus therefore draws probes near the programmed value or near the range bounds, and flips only a few bits between samples. Directed sequences then cover the inclusive bounds, the target limits of 0 and maximum, and an arm that coincides with a match.

// File: rtl/trm_pkg.sv
package trm_pkg;

  typedef enum logic [2:0] {
    CLS_BASIC   = 3'd0,
    CLS_BASIC_E = 3'd1,
    CLS_EXT     = 3'd2,
    CLS_EXT_E   = 3'd3,
    CLS_RANGE   = 3'd4,
    CLS_RANGE_E = 3'd5,
    CLS_OFF6    = 3'd6,
    CLS_OFF7    = 3'd7
  } cls_e;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_GT  = 3'd2,
    REL_GE  = 3'd3,
    REL_LT  = 3'd4,
    REL_LE  = 3'd5,
    REL_NO6 = 3'd6,
    REL_NO7 = 3'd7
  } rel_e;

  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_VALUE = 3'd1;
  localparam logic [2:0] A_CARE  = 3'd2;
  localparam logic [2:0] A_RISE  = 3'd3;
  localparam logic [2:0] A_FALL  = 3'd4;
  localparam logic [2:0] A_LOW   = 3'd5;
  localparam logic [2:0] A_HIGH  = 3'd6;
  localparam logic [2:0] A_TGT   = 3'd7;

  // True when every bit selected by msk agrees between cur and val.
  function automatic logic lvl_match(logic [63:0] cur, logic [63:0] val, logic [63:0] msk);
    return ((cur ^ val) & msk) == 64'd0;
  endfunction

  // Edge requirement over the bits selected by re/fe.
  function automatic logic edge_hold(logic [63:0] cur, logic [63:0] prv, logic pv,
                                     logic [63:0] re, logic [63:0] fe);
    logic [63:0] sel;
    logic [63:0] seen;
    sel  = re | fe;
    seen = (re & ~prv & cur) | (fe & prv & ~cur);
    if (sel == 64'd0) return 1'b1;
    return pv && (seen == sel);
  endfunction

  // Unsigned relation between the masked probe a and masked reference b.
  function automatic logic rel_hold(logic [63:0] a, logic [63:0] b, rel_e r);
    case (r)
      REL_EQ:  return a == b;
      REL_NE:  return a != b;
      REL_GT:  return a >  b;
      REL_GE:  return a >= b;
      REL_LT:  return a <  b;
      REL_LE:  return a <= b;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trm_cfg_regs.sv
module trm_cfg_regs
  import trm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output cls_e             cls_o,
  output rel_e             rel_o,
  output logic [WIDTH-1:0] val_o,
  output logic [WIDTH-1:0] care_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o,
  output logic [WIDTH-1:0] lo_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [CW-1:0]    tgt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_o  <= CLS_OFF7;
      rel_o  <= REL_EQ;
      val_o  <= '0;
      care_o <= '0;
      rise_o <= '0;
      fall_o <= '0;
      lo_o   <= '0;
      hi_o   <= '0;
      tgt_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MODE: begin
          cls_o <= cls_e'(wdata_i[2:0]);
          rel_o <= rel_e'(wdata_i[5:3]);
        end
        A_VALUE: val_o  <= wdata_i;
        A_CARE:  care_o <= wdata_i;
        A_RISE:  rise_o <= wdata_i;
        A_FALL:  fall_o <= wdata_i;
        A_LOW:   lo_o   <= wdata_i;
        A_HIGH:  hi_o   <= wdata_i;
        default: tgt_o  <= wdata_i[CW-1:0];
      endcase
    end
  end

endmodule

// File: rtl/trm_compare.sv
module trm_compare
  import trm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter bit EXT_OK = 1'b1,
  parameter bit GRP_ON = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] probe_i,
  input  cls_e             cls_i,
  input  rel_e             rel_i,
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] care_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] fall_i,
  input  logic [WIDTH-1:0] lo_i,
  input  logic [WIDTH-1:0] hi_i,
  output logic             raw_o
);

  logic [WIDTH-1:0] prev;
  logic             pv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      pv   <= 1'b0;
    end else begin
      prev <= probe_i;
      pv   <= 1'b1;
    end
  end

  logic             edge_mode;
  logic [WIDTH-1:0] edge_bits;
  logic [WIDTH-1:0] lvl_mask;
  logic [WIDTH-1:0] masked;
  logic [WIDTH-1:0] ref_m;
  logic             lvl_ok, edge_ok, rel_ok, rng_ok;
  logic             cls_hit, cls_allowed;

  assign edge_mode = (cls_i == CLS_BASIC_E) || (cls_i == CLS_EXT_E) || (cls_i == CLS_RANGE_E);
  assign edge_bits = rise_i | fall_i;
  assign lvl_mask  = edge_mode ? (care_i & ~edge_bits) : care_i;
  assign masked    = probe_i & care_i;
  assign ref_m     = val_i & care_i;

  assign lvl_ok  = lvl_match(64'(probe_i), 64'(val_i), 64'(lvl_mask));
  assign edge_ok = edge_hold(64'(probe_i), 64'(prev), pv, 64'(rise_i), 64'(fall_i));
  assign rel_ok  = rel_hold(64'(masked), 64'(ref_m), rel_i);
  assign rng_ok  = (masked >= lo_i) && (masked <= hi_i);

  always_comb begin
    case (cls_i)
      CLS_BASIC:   cls_hit = lvl_ok;
      CLS_BASIC_E: cls_hit = lvl_ok && edge_ok;
      CLS_EXT:     cls_hit = rel_ok;
      CLS_EXT_E:   cls_hit = rel_ok && edge_ok;
      CLS_RANGE:   cls_hit = rng_ok;
      CLS_RANGE_E: cls_hit = rng_ok && edge_ok;
      default:     cls_hit = 1'b0;
    endcase
  end

  assign cls_allowed = EXT_OK || (cls_i == CLS_BASIC) || (cls_i == CLS_BASIC_E);
  assign raw_o       = GRP_ON && cls_allowed && cls_hit;

  // R3
  edge_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && (|edge_bits) && !pv) |-> !raw_o);

  // R12
  off_class_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_i == CLS_OFF6) || (cls_i == CLS_OFF7)) |-> !raw_o);

endmodule

// File: rtl/trm_occ_counter.sv
module trm_occ_counter #(
  parameter int CNT_W = 4,
  parameter int CW    = (CNT_W == 0) ? 1 : CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          match_i,
  input  logic [CW-1:0] tgt_i,
  output logic          hit_o
);

  generate
    if (CNT_W == 0) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_o <= 1'b0;
        else        hit_o <= match_i && !arm_i;
      end

      // R9
      every_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == $past(match_i && !arm_i));
    end else begin : g_count
      logic [CW-1:0] cnt;
      logic [CW:0]   nxt;
      logic [CW:0]   tgt_eff;

      assign nxt     = {1'b0, cnt} + 1'b1;
      assign tgt_eff = (tgt_i == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, tgt_i};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt   <= '0;
          hit_o <= 1'b0;
        end else if (arm_i) begin
          cnt   <= '0;
          hit_o <= 1'b0;
        end else if (match_i) begin
          if (nxt >= tgt_eff) begin
            cnt   <= '0;
            hit_o <= 1'b1;
          end else begin
            cnt   <= nxt[CW-1:0];
            hit_o <= 1'b0;
          end
        end else begin
          hit_o <= 1'b0;
        end
      end

      // R8
      hit_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(match_i) && !$past(arm_i)));

      // R10
      arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> ((cnt == '0) && !hit_o));
    end
  endgenerate

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int CNT_W  = 4,
  parameter bit EXT_OK = 1'b1,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [WIDTH-1:0] cfg_wdata_i,
  input  logic [WIDTH-1:0] probe_i,
  output logic             match_o
);

  localparam int CW = (CNT_W == 0) ? 1 : CNT_W;

  cls_e             cls_w;
  rel_e             rel_w;
  logic [WIDTH-1:0] val_w, care_w, rise_w, fall_w, lo_w, hi_w;
  logic [CW-1:0]    tgt_w;
  logic             raw_hit;

  trm_cfg_regs #(.WIDTH(WIDTH), .CW(CW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cls_o  (cls_w),
    .rel_o  (rel_w),
    .val_o  (val_w),
    .care_o (care_w),
    .rise_o (rise_w),
    .fall_o (fall_w),
    .lo_o   (lo_w),
    .hi_o   (hi_w),
    .tgt_o  (tgt_w)
  );

  trm_compare #(.WIDTH(WIDTH), .EXT_OK(EXT_OK), .GRP_ON(ENABLE)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .probe_i(probe_i),
    .cls_i  (cls_w),
    .rel_i  (rel_w),
    .val_i  (val_w),
    .care_i (care_w),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .lo_i   (lo_w),
    .hi_i   (hi_w),
    .raw_o  (raw_hit)
  );

  trm_occ_counter #(.CNT_W(CNT_W), .CW(CW)) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (arm_i),
    .match_i(raw_hit),
    .tgt_i  (tgt_w),
    .hit_o  (match_o)
  );

  generate
    if (!ENABLE) begin : g_off
      // R11
      off_group_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o);
    end
    if (!EXT_OK) begin : g_narrow
      // R7
      narrow_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cls_w != CLS_BASIC) && (cls_w != CLS_BASIC_E)) |=> !match_o);
    end
  endgenerate

endmodule

// File: tb/trig_match_unit_tb.sv
module trig_match_unit_tb;
  localparam int W  = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, arm, we;
  logic [2:0]   addr;
  logic [W-1:0] wdata, probe;
  logic         m_dut, m_nar, m_one, m_off;

  trig_match_unit #(.WIDTH(W), .CNT_W(CW), .EXT_OK(1'b1), .ENABLE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .probe_i(probe), .match_o(m_dut));
  trig_match_unit #(.WIDTH(W), .CNT_W(CW), .EXT_OK(1'b0), .ENABLE(1'b1)) u_nar (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .probe_i(probe), .match_o(m_nar));
  trig_match_unit #(.WIDTH(W), .CNT_W(0), .EXT_OK(1'b1), .ENABLE(1'b1)) u_one (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .probe_i(probe), .match_o(m_one));
  trig_match_unit #(.WIDTH(W), .CNT_W(CW), .EXT_OK(1'b1), .ENABLE(1'b0)) u_off (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .probe_i(probe), .match_o(m_off));

  int vectors = 0;
  int fails   = 0;

  // Shadow of the configuration and of the history, kept by the bench.
  int unsigned  s_cls, s_rel, s_tgt;
  logic [W-1:0] s_val, s_care, s_rise, s_fall, s_lo, s_hi;
  logic [W-1:0] h_prev;
  bit           h_pv;
  int           cnt_a, cnt_b;

  task automatic chk(logic act, logic exp, string tag, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic bit rel_true(int unsigned a, int unsigned b, int unsigned r);
    if (r == 0) return a == b;
    if (r == 1) return a != b;
    if (r == 2) return a > b;
    if (r == 3) return a >= b;
    if (r == 4) return a < b;
    if (r == 5) return a <= b;
    return 1'b0;
  endfunction

  function automatic bit mdl_raw(logic [W-1:0] p, bit ext_ok);
    bit lvl, edg, anyedge, em;
    int unsigned mp, mv;
    em = (s_cls == 1) || (s_cls == 3) || (s_cls == 5);
    lvl = 1; edg = 1; anyedge = 0;
    for (int i = 0; i < W; i++) begin
      if (em && (s_rise[i] || s_fall[i])) begin
        anyedge = 1;
        if (!((s_rise[i] && !h_prev[i] && p[i]) || (s_fall[i] && h_prev[i] && !p[i])))
          edg = 0;
      end else if (s_care[i] && (p[i] != s_val[i])) begin
        lvl = 0;
      end
    end
    if (anyedge && !h_pv) edg = 0;
    mp = 32'(p & s_care);
    mv = 32'(s_val & s_care);
    if (!ext_ok && s_cls >= 2) return 1'b0;
    case (s_cls)
      0: return lvl;
      1: return lvl && edg;
      2: return rel_true(mp, mv, s_rel);
      3: return rel_true(mp, mv, s_rel) && edg;
      4: return (mp >= 32'(s_lo)) && (mp <= 32'(s_hi));
      5: return (mp >= 32'(s_lo)) && (mp <= 32'(s_hi)) && edg;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit occ(ref int cnt, input bit raw, input bit a);
    int unsigned lim;
    lim = (s_tgt == 0) ? 1 : s_tgt;
    if (a) begin cnt = 0; return 1'b0; end
    if (!raw) return 1'b0;
    if (cnt + 1 >= lim) begin cnt = 0; return 1'b1; end
    cnt++;
    return 1'b0;
  endfunction

  function automatic string cls_tag();
    case (s_cls)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      4: return "R5";
      3, 5: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic step(logic [W-1:0] p, bit a, string tag);
    bit ra, rb, ea, eb, eo;
    @(negedge clk);
    we = 1'b0; probe = p; arm = a;
    ra = mdl_raw(p, 1'b1);
    rb = mdl_raw(p, 1'b0);
    ea = occ(cnt_a, ra, a);
    eb = occ(cnt_b, rb, a);
    eo = ra && !a;
    h_prev = p; h_pv = 1'b1;
    @(posedge clk); #2;
    chk(m_dut, ea, tag, "main match");
    chk(m_nar, eb, "R7", "narrow group");
    chk(m_one, eo, "R9", "zero-width counter");
    chk(m_off, 1'b0, "R11", "disabled group");
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; arm = 1'b1;
    case (a)
      3'd0: begin s_cls = 32'(d[2:0]); s_rel = 32'(d[5:3]); end
      3'd1: s_val  = d;
      3'd2: s_care = d;
      3'd3: s_rise = d;
      3'd4: s_fall = d;
      3'd5: s_lo   = d;
      3'd6: s_hi   = d;
      default: s_tgt = 32'(d[CW-1:0]);
    endcase
    cnt_a = 0; cnt_b = 0;
    h_prev = probe; h_pv = 1'b1;
    @(posedge clk); #2;
    chk(m_dut, 1'b0, "R10", "arm during write");
    chk(m_one, 1'b0, "R10", "arm during write");
  endtask

  task automatic setup(int unsigned c, int unsigned r, logic [W-1:0] v, logic [W-1:0] cr,
                       logic [W-1:0] ri, logic [W-1:0] fa, logic [W-1:0] lo,
                       logic [W-1:0] hi, int unsigned t);
    wr(3'd1, v); wr(3'd2, cr); wr(3'd3, ri); wr(3'd4, fa);
    wr(3'd5, lo); wr(3'd6, hi); wr(3'd7, W'(t));
    wr(3'd0, W'({r[2:0], c[2:0]}));
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unsigned junk;
    logic [W-1:0] p;
    junk = $urandom(32'h5eed);
    rst_n = 1'b0; arm = 0; we = 0; addr = 0; wdata = 0; probe = 0;
    s_cls = 7; s_rel = 0; s_tgt = 0; s_val = 0; s_care = 0; s_rise = 0; s_fall = 0;
    s_lo = 0; s_hi = 0; h_prev = 0; h_pv = 0; cnt_a = 0; cnt_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_dut, 1'b0, "R1", "in reset");
    chk(m_one, 1'b0, "R1", "in reset");
    rst_n = 1'b1;
    // R1: class off after reset, no match on any probe
    step(16'h0000, 0, "R1"); step(16'hFFFF, 0, "R1"); step(16'h1234, 0, "R1");

    // R2: basic, don't-care bits, edge registers ignored
    setup(0, 0, 16'h00A5, 16'h00FF, 16'h0001, 16'h0000, 0, 0, 1);
    step(16'h12A5, 0, "R2"); step(16'h00A4, 0, "R2"); step(16'hFFA5, 0, "R2");

    // R3: rising on bit 0, falling on bit 1, both on bit 2, level on bit 4
    setup(1, 0, 16'h0010, 16'h0010, 16'h0005, 16'h0006, 0, 0, 1);
    step(16'h0012, 0, "R3"); step(16'h0015, 0, "R3"); step(16'h0010, 0, "R3");
    step(16'h0012, 0, "R3"); step(16'h0011, 0, "R3"); step(16'h0005, 0, "R3");

    // R4: each relation
    for (int r = 0; r < 8; r++) begin
      setup(2, r, 16'h0040, 16'h00FF, 0, 0, 0, 0, 1);
      step(16'h3F3F, 0, "R4"); step(16'h0040, 0, "R4"); step(16'hAA41, 0, "R4");
    end

    // R5: inclusive bounds
    setup(4, 0, 0, 16'hFFFF, 0, 0, 16'h0010, 16'h0020, 1);
    step(16'h000F, 0, "R5"); step(16'h0010, 0, "R5"); step(16'h0020, 0, "R5");
    step(16'h0021, 0, "R5");

    // R6: range with a rising edge on bit 15
    setup(5, 0, 0, 16'h00FF, 16'h8000, 0, 16'h0010, 16'h0020, 1);
    step(16'h0015, 0, "R6"); step(16'h8015, 0, "R6"); step(16'h8015, 0, "R6");
    step(16'h0030, 0, "R6"); step(16'h8030, 0, "R6");

    // R8: target 3, then target 0, then max target
    setup(0, 0, 16'h0001, 16'h0001, 0, 0, 0, 0, 3);
    for (int i = 0; i < 8; i++) step(16'h0001, 0, "R8");
    setup(0, 0, 16'h0001, 16'h0001, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(16'h0001, 0, "R8");
    setup(0, 0, 16'h0001, 16'h0001, 0, 0, 0, 0, 15);
    for (int i = 0; i < 32; i++) step(16'h0001, 0, "R8");

    // R10: arm in the same cycle as the qualifying match
    setup(0, 0, 16'h0001, 16'h0001, 0, 0, 0, 0, 2);
    step(16'h0001, 0, "R10"); step(16'h0001, 1, "R10");
    step(16'h0001, 0, "R10"); step(16'h0001, 0, "R10");

    // Random campaign over all class codes
    for (int k = 0; k < 80; k++) begin
      int unsigned c, r, t;
      logic [W-1:0] v, cr, ri, fa, lo, hi;
      c  = $urandom_range(0, 7);
      r  = $urandom_range(0, 7);
      t  = $urandom_range(0, 4);
      v  = W'($urandom);
      cr = W'($urandom) | W'($urandom);
      ri = W'($urandom) & W'($urandom) & W'($urandom);
      fa = W'($urandom) & W'($urandom) & W'($urandom);
      lo = W'($urandom_range(0, 16'h7FFF));
      hi = lo + W'($urandom_range(0, 16'h3FFF));
      setup(c, r, v, cr, ri, fa, lo, hi, t);
      p = v;
      for (int i = 0; i < 60; i++) begin
        int unsigned sel;
        sel = $urandom_range(0, 9);
        if (sel < 2)      p = W'($urandom);
        else if (sel < 4) p = (lo + W'($urandom_range(0, 3))) | (p & ~cr);
        else if (sel < 6) p = v;
        else              p = p ^ (W'(1) << $urandom_range(0, W - 1));
        step(p, ($urandom_range(0, 31) == 0), cls_tag());
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule